// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial frames for a multidrop line on which one master talks to many listeners. Each frame holds a start bit, a data byte sent least significant bit first, a ninth bit and a stop bit. In multiprocessor format the ninth bit marks the frame as an address (1) or as data (0). In plain format it is an even-parity bit. The line is oversampled with an external sample tick running at OVS times the bit rate. Every bit is sampled once, near its middle. A received byte moves from the shift register into a holding data register. Status flags and two interrupt outputs report the result.

Software arms an address filter by writing 1 to the filter enable while multiprocessor format is selected. While the filter is armed, data frames are discarded without a trace: no transfer, no flag, no interrupt. The first address frame is accepted and sets the ninth-bit status. That frame also disarms the filter in hardware, so the listener sees all traffic that follows until software arms the filter again.

Top module: `mpu_rx`

## Requirements
- R1: A reception starts only on a sample tick with `rx_en`=1 and the line low, and only if the line is still low at the middle of the start bit. A shorter low pulse is discarded. With `rx_en`=0 no reception starts.
- R2: Dropping `rx_en` to 0 leaves `rdrf`, `fer`, `per` and `orer` at their current values.
- R3: Frame order on the line is start (0), data bits 0 to 7, ninth bit, stop. An accepted frame with `rdrf`=0 copies the byte into `rx_data` and sets `rdrf`.
- R4: A loaded frame whose stop bit is sampled low sets `fer`. The byte is still loaded.
- R5: With `mp_fmt`=0 the ninth bit is an even-parity bit over the byte. A mismatch on a loaded frame sets `per`. In this format `mp_ie` has no effect on reception.
- R6: `mp_ie` resets to 0. A software write (`mp_ie_wr`=1 with `mp_ie_wdata`) takes effect in the next cycle.
- R7: With `mp_fmt`=1 and `mp_ie`=1, a frame whose ninth bit is 0 is discarded. `rx_data`, `rdrf`, `fer` and `orer` are left unchanged, and `mp_ie` stays 1.
- R8: With `mp_fmt`=1 and `mp_ie`=1, a frame whose ninth bit is 1 is accepted. It sets `mpb` and clears `mp_ie`. This hardware clear wins over a software write in the same cycle.
- R9: A frame accepted while `rdrf`=1 sets `orer` and leaves `rx_data`, `fer` and `per` unchanged.
- R10: `rxi` = `rie` AND `rdrf`. `eri` = `rie` AND (`fer` OR `per` OR `orer`).
- R11: Each flag is cleared by a one-cycle strobe on its clear input. A hardware set in the same cycle wins.
- R12: With `mp_fmt`=1 and `mp_ie`=0, every frame is accepted and `mpb` takes the value of its ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe at OVS times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| mp_fmt | input | 1 | 1: ninth bit is the multiprocessor bit; 0: even parity |
| mp_ie_wr | input | 1 | Software write strobe for the filter enable |
| mp_ie_wdata | input | 1 | Value written to the filter enable |
| rie | input | 1 | Interrupt enable for `rxi` and `eri` |
| clr_rdrf | input | 1 | Clears receive-full |
| clr_fer | input | 1 | Clears framing error |
| clr_per | input | 1 | Clears parity error |
| clr_orer | input | 1 | Clears overrun |
| rx_data | output | DW | Received byte |
| rdrf | output | 1 | Receive-full flag |
| fer | output | 1 | Framing-error flag |
| per | output | 1 | Parity-error flag |
| orer | output | 1 | Overrun flag |
| mpb | output | 1 | Ninth bit of the last accepted multiprocessor frame |
| mp_ie | output | 1 | Address filter enable |
| rxi | output | 1 | Receive interrupt |
| eri | output | 1 | Receive-error interrupt |

## Verification
The bench builds the receiver with OVS=8 and raises the tick only on every other clock, so one bit lasts 16 clocks and a frame takes under 200. The gapped tick checks that the counters advance only on tick cycles. The short bit time leaves room for whole scenarios in a short run: filter sequences with several frames, an overrun after a held frame, and a start glitch shorter than half a bit.

// File: rtl/mpu_rx.sv
module mpu_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic          mp_fmt,
  input  logic          mp_ie_wr,
  input  logic          mp_ie_wdata,
  input  logic          rie,
  input  logic          clr_rdrf,
  input  logic          clr_fer,
  input  logic          clr_per,
  input  logic          clr_orer,
  output logic [DW-1:0] rx_data,
  output logic          rdrf,
  output logic          fer,
  output logic          per,
  output logic          orer,
  output logic          mpb,
  output logic          mp_ie,
  output logic          rxi,
  output logic          eri
);
  localparam int CW   = $clog2(OVS);
  localparam int LAST = DW + 2;
  localparam int IW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] WRAP = CW'(OVS - 1);

  logic [1:0]    sync;
  logic          busy, b9;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;

  wire rx_s   = sync[1];
  wire samp   = busy & tick & (cnt == MID);
  wire done   = samp & (idx == IW'(LAST));
  wire filt   = mp_fmt & mp_ie;
  wire drop   = done & filt & ~b9;
  wire take   = done & ~drop;
  wire load   = take & ~rdrf;
  wire hw_clr = take & filt;

  assign rxi = rie & rdrf;
  assign eri = rie & (fer | per | orer);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b11;
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      b9   <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      if (!busy) begin
        if (tick && rx_en && !rx_s) begin
          busy <= 1'b1;
          cnt  <= '0;
          idx  <= '0;
        end
      end else if (tick) begin
        cnt <= (cnt == WRAP) ? '0 : cnt + 1'b1;
        if (cnt == MID) begin
          idx <= idx + 1'b1;
          if ((idx == '0 && rx_s) || idx == IW'(LAST)) busy <= 1'b0;
          if (idx >= IW'(1) && idx <= IW'(DW)) sh <= {rx_s, sh[DW-1:1]};
          if (idx == IW'(DW + 1)) b9 <= rx_s;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      rdrf    <= 1'b0;
      fer     <= 1'b0;
      per     <= 1'b0;
      orer    <= 1'b0;
      mpb     <= 1'b0;
      mp_ie   <= 1'b0;
    end else begin
      if (load) rx_data <= sh;
      rdrf <= load | (rdrf & ~clr_rdrf);
      fer  <= (load & ~rx_s) | (fer & ~clr_fer);
      per  <= (load & ~mp_fmt & (^{sh, b9})) | (per & ~clr_per);
      orer <= (take & rdrf) | (orer & ~clr_orer);
      if (take && mp_fmt) mpb <= b9;
      if (hw_clr)        mp_ie <= 1'b0;
      else if (mp_ie_wr) mp_ie <= mp_ie_wdata;
    end
  end

  assert_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_en) |=> !busy);
  assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdrf && !clr_rdrf) |=> rdrf);
  assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (!$rose(rdrf) && !$rose(fer) && !$rose(orer) && $stable(rx_data)));
  assert_hw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && filt && b9) |=> (!mp_ie && mpb));
  assert_ovr_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !drop && rdrf) |=> ($stable(rx_data) && orer));
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rie |-> (!rxi && !eri));
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && clr_rdrf) |=> rdrf);
endmodule

// File: tb/mpu_rx_tb.sv
module mpu_rx_tb;
  localparam int OVS = 8;
  localparam int BIT = 2 * OVS;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic rx_en = 1'b0, mp_fmt = 1'b0, mp_ie_wr = 1'b0, mp_ie_wdata = 1'b0, rie = 1'b0;
  logic clr_rdrf = 1'b0, clr_fer = 1'b0, clr_per = 1'b0, clr_orer = 1'b0;
  logic [7:0] rx_data;
  logic rdrf, fer, per, orer, mpb, mp_ie, rxi, eri;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mpu_rx #(.OVS(OVS), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
    .mp_fmt(mp_fmt), .mp_ie_wr(mp_ie_wr), .mp_ie_wdata(mp_ie_wdata), .rie(rie),
    .clr_rdrf(clr_rdrf), .clr_fer(clr_fer), .clr_per(clr_per), .clr_orer(clr_orer),
    .rx_data(rx_data), .rdrf(rdrf), .fer(fer), .per(per), .orer(orer),
    .mpb(mpb), .mp_ie(mp_ie), .rxi(rxi), .eri(eri));

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stop);
    logic [10:0] f;
    f = {stop, b9, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = f[i];
      idle(BIT);
    end
    rxd = 1'b1;
    idle(BIT + 4);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    idle(1);
    s = 1'b0;
    idle(1);
  endtask

  task automatic write_mpie(input logic v);
    mp_ie_wdata = v;
    mp_ie_wr = 1'b1;
    idle(1);
    mp_ie_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R6 mp_ie reset", mp_ie, 0);
    check("R3 rdrf reset", rdrf, 0);
    check("R10 irq reset", {rxi, eri, fer, per, orer, mpb}, 0);
  endtask

  task automatic t_plain;
    send(8'hA5, 1'b0, 1'b1);
    check("R3 data", rx_data, 8'hA5);
    check("R3 rdrf", rdrf, 1);
    check("R5 parity ok", per, 0);
    check("R10 rxi", rxi, 1);
    pulse(clr_rdrf);
    check("R11 clr rdrf", rdrf, 0);
  endtask

  task automatic t_parity;
    send(8'h01, 1'b0, 1'b1);
    check("R5 per set", per, 1);
    check("R10 eri", eri, 1);
    pulse(clr_per);
    pulse(clr_rdrf);
    check("R11 clr per", {per, eri}, 0);
  endtask

  task automatic t_framing;
    send(8'h3C, 1'b0, 1'b0);
    check("R4 fer", fer, 1);
    check("R4 data loaded", rx_data, 8'h3C);
    pulse(clr_fer);
    pulse(clr_rdrf);
    check("R11 clr fer", {fer, rdrf}, 0);
  endtask

  task automatic t_overrun;
    send(8'h5A, 1'b0, 1'b1);
    send(8'hC3, 1'b0, 1'b1);
    check("R9 orer", orer, 1);
    check("R9 data kept", rx_data, 8'h5A);
    check("R9 per untouched", per, 0);
    rx_en = 1'b0;
    idle(3);
    check("R2 flags hold", {rdrf, orer}, 2'b11);
    send(8'h00, 1'b0, 1'b1);
    check("R1 disabled no rx", rx_data, 8'h5A);
    pulse(clr_orer);
    pulse(clr_rdrf);
    check("R11 clr orer", {orer, rdrf}, 0);
    rx_en = 1'b1;
  endtask

  task automatic t_glitch;
    rxd = 1'b0;
    idle(4);
    rxd = 1'b1;
    idle(3 * BIT);
    check("R1 glitch ignored", rdrf, 0);
  endtask

  task automatic t_filter;
    mp_fmt = 1'b1;
    write_mpie(1'b1);
    check("R6 write immediate", mp_ie, 1);
    send(8'h11, 1'b0, 1'b1);
    send(8'h12, 1'b0, 1'b0);
    check("R7 dropped", {rdrf, fer, orer}, 0);
    check("R7 data kept", rx_data, 8'h5A);
    check("R7 filter stays", mp_ie, 1);
    send(8'h42, 1'b1, 1'b1);
    check("R8 mpb", mpb, 1);
    check("R8 filter cleared", mp_ie, 0);
    check("R8 address data", rx_data, 8'h42);
    check("R8 rxi", rxi, 1);
    pulse(clr_rdrf);
    send(8'h77, 1'b0, 1'b1);
    check("R12 data accepted", rx_data, 8'h77);
    check("R12 mpb follows", mpb, 0);
    pulse(clr_rdrf);
  endtask

  task automatic t_ignore;
    mp_fmt = 1'b0;
    write_mpie(1'b1);
    send(8'h03, 1'b0, 1'b1);
    check("R5 mp_ie ignored", rx_data, 8'h03);
    check("R5 rdrf", {rdrf, per}, 2'b10);
    rie = 1'b0;
    idle(1);
    check("R10 gated", {rxi, eri}, 0);
    pulse(clr_rdrf);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    rx_en = 1'b1;
    rie = 1'b1;
    t_plain();
    t_parity();
    t_framing();
    t_glitch();
    t_overrun();
    t_filter();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule